// File: doc/BRIEF.md
# Upstream Configuration Claim Decoder

This block sits behind the upstream PCI-X interface of a bridge. It looks at the address phase of each incoming configuration transaction and decides whether the bridge itself is the target. The bridge has no select pin of its own. It keeps device number 0 for itself and treats a single fixed address bit (bit 16) as its select line. A claim is made only when a software-controlled enable bit is set.

On a claim, the block passes a dword index into the 4 KB configuration space to the register file that follows it. The index is built from the extended-register bits and the register bits of the address. The device and function fields carried in the address are not used. The bridge's own device number, which is reported outward, is never loaded from them.

A one-bit control port lets software set or clear the enable. Data phases, split completions, Type 1 forwarding and bus signalling are handled elsewhere.

Top module: `cfg_claim_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `claim_o` is 0, `reg_index_o` is 0 and `cfg_enable_o` is 0.
- R2: A cycle with `csr_wr_i` high loads `csr_wdata_i` into the enable bit. The new value appears on `cfg_enable_o` after that clock edge. Without a write, the bit holds its value.
- R3: An address phase (`addr_valid_i` high) is claimed when all four of these hold: `cmd_is_cfg_i` is 1, `ad_i[1:0]` is 00, `ad_i[16]` is 1, and the enable bit is 1. `claim_o` is then 1 during the next cycle.
- R4: While the enable bit is 0, no address phase is claimed.
- R5: An address phase with `ad_i[16]` equal to 0 is not claimed.
- R6: An address phase whose command is not a configuration command, or whose `ad_i[1:0]` is not 00, is not claimed, whatever the value of bit 16.
- R7: The device field `ad_i[15:11]` and the function field `ad_i[10:8]` have no effect on either the claim or the index.
- R8: In the cycle after a claimed phase, `reg_index_o` equals `{ad_i[27:24], ad_i[7:2]}` of that phase. It holds that value until the next claim.
- R9: `primary_dev_o` reports device number 0 at all times. It is never changed by the device field of any transaction.
- R10: `claim_o` is high only in the cycle that follows an address phase, so an isolated phase gives a one-cycle pulse.
- R11: A control write in the same cycle as an address phase takes effect only for later phases. That phase is judged with the enable value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid_i | input | 1 | High for the one cycle of an address phase |
| cmd_is_cfg_i | input | 1 | Command of this phase is a configuration read or write |
| ad_i | input | 32 | Address/data bus sampled in the address phase |
| csr_wr_i | input | 1 | Write strobe for the enable control bit |
| csr_wdata_i | input | 1 | Value written to the enable control bit |
| cfg_enable_o | output | 1 | Current value of the enable control bit |
| claim_o | output | 1 | Bridge claims the previous address phase |
| reg_index_o | output | 10 | Configuration-space dword index of the last claim |
| primary_dev_o | output | 5 | Device number the bridge reports for itself |

## Verification
The properties assume that every input is a known value at each rising edge. They also assume that `ad_i` and `cmd_is_cfg_i` carry meaningful values whenever `addr_valid_i` is high, and that `addr_valid_i` stays low while reset is asserted. The bench changes every input on the falling edge and keeps reset asserted for several cycles with all strobes low. Each address phase is driven with fully defined bus and command values, so the claim and index properties only ever see clean address phases.

// File: rtl/cfg_claim_pkg.sv
package cfg_claim_pkg;

    // Default address geometry of an upstream Type 0 configuration cycle
    localparam int unsigned ADDR_W_DEF   = 32;
    localparam int unsigned SEL_BIT_DEF  = 16;
    localparam int unsigned TYPE_W_DEF   = 2;
    localparam int unsigned REG_LSB_DEF  = 2;
    localparam int unsigned REG_W_DEF    = 6;
    localparam int unsigned EXT_LSB_DEF  = 24;
    localparam int unsigned EXT_W_DEF    = 4;
    localparam int unsigned DEV_W_DEF    = 5;

    // Why an address phase was or was not taken
    typedef enum logic [2:0] {
        VERDICT_CLAIM     = 3'd0,
        VERDICT_NOT_CFG   = 3'd1,
        VERDICT_BAD_TYPE  = 3'd2,
        VERDICT_DISABLED  = 3'd3,
        VERDICT_NO_SELECT = 3'd4
    } verdict_e;

endpackage

// File: rtl/cfg_addr_split.sv
module cfg_addr_split
    import cfg_claim_pkg::*;
#(
    parameter int unsigned ADDR_W  = ADDR_W_DEF,
    parameter int unsigned SEL_BIT = SEL_BIT_DEF,
    parameter int unsigned TYPE_W  = TYPE_W_DEF,
    parameter int unsigned REG_LSB = REG_LSB_DEF,
    parameter int unsigned REG_W   = REG_W_DEF,
    parameter int unsigned EXT_LSB = EXT_LSB_DEF,
    parameter int unsigned EXT_W   = EXT_W_DEF,
    localparam int unsigned IDX_W  = EXT_W + REG_W
) (
    input  logic [ADDR_W-1:0] ad_i,
    output logic              type0_o,
    output logic              select_o,
    output logic [IDX_W-1:0]  index_o
);

    // Device and function bits are deliberately not decoded here
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] USED_MASK =
          (((ONE << TYPE_W) - ONE))
        | (ONE << SEL_BIT)
        | (((ONE << REG_W) - ONE) << REG_LSB)
        | (((ONE << EXT_W) - ONE) << EXT_LSB);

    logic [ADDR_W-1:0] unused_ad_bits;
    assign unused_ad_bits = ad_i & ~USED_MASK;

    always_comb begin
        type0_o  = (ad_i[TYPE_W-1:0] == '0);
        select_o = ad_i[SEL_BIT];
        index_o  = {ad_i[EXT_LSB +: EXT_W], ad_i[REG_LSB +: REG_W]};
    end

endmodule

// File: rtl/cfg_enable_reg.sv
module cfg_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wdata_i,
    output logic enable_o
);

    logic enable_d;
    logic enable_q;

    always_comb begin
        enable_d = enable_q;
        if (wr_i) begin
            enable_d = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
        end else begin
            enable_q <= enable_d;
        end
    end

    assign enable_o = enable_q;

endmodule

// File: rtl/cfg_claim_stage.sv
module cfg_claim_stage
    import cfg_claim_pkg::*;
#(
    parameter int unsigned IDX_W = EXT_W_DEF + REG_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             is_cfg_i,
    input  logic             type0_i,
    input  logic             select_i,
    input  logic             enable_i,
    input  logic [IDX_W-1:0] index_i,
    output logic             claim_o,
    output logic [IDX_W-1:0] index_o
);

    typedef struct packed {
        logic             claim;
        logic [IDX_W-1:0] index;
    } stage_t;

    stage_t   st_d;
    stage_t   st_q;
    verdict_e verdict;

    always_comb begin
        // Ordered checks: command, header type, enable, then select bit
        if (!is_cfg_i) begin
            verdict = VERDICT_NOT_CFG;
        end else if (!type0_i) begin
            verdict = VERDICT_BAD_TYPE;
        end else if (!enable_i) begin
            verdict = VERDICT_DISABLED;
        end else if (!select_i) begin
            verdict = VERDICT_NO_SELECT;
        end else begin
            verdict = VERDICT_CLAIM;
        end

        st_d       = st_q;
        st_d.claim = valid_i && (verdict == VERDICT_CLAIM);
        if (st_d.claim) begin
            st_d.index = index_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign claim_o = st_q.claim;
    assign index_o = st_q.index;

endmodule

// File: rtl/cfg_claim_decoder.sv
module cfg_claim_decoder
    import cfg_claim_pkg::*;
#(
    parameter int unsigned ADDR_W   = ADDR_W_DEF,
    parameter int unsigned SEL_BIT  = SEL_BIT_DEF,
    parameter int unsigned REG_LSB  = REG_LSB_DEF,
    parameter int unsigned REG_W    = REG_W_DEF,
    parameter int unsigned EXT_LSB  = EXT_LSB_DEF,
    parameter int unsigned EXT_W    = EXT_W_DEF,
    parameter int unsigned DEV_W    = DEV_W_DEF,
    parameter logic [DEV_W-1:0] SELF_DEV = '0,
    localparam int unsigned IDX_W   = EXT_W + REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid_i,
    input  logic              cmd_is_cfg_i,
    input  logic [ADDR_W-1:0] ad_i,
    input  logic              csr_wr_i,
    input  logic              csr_wdata_i,
    output logic              cfg_enable_o,
    output logic              claim_o,
    output logic [IDX_W-1:0]  reg_index_o,
    output logic [DEV_W-1:0]  primary_dev_o
);

    logic             type0;
    logic             select;
    logic [IDX_W-1:0] index_c;
    logic [DEV_W-1:0] self_dev_d;
    logic [DEV_W-1:0] self_dev_q;

    cfg_addr_split #(
        .ADDR_W  (ADDR_W),
        .SEL_BIT (SEL_BIT),
        .TYPE_W  (TYPE_W_DEF),
        .REG_LSB (REG_LSB),
        .REG_W   (REG_W),
        .EXT_LSB (EXT_LSB),
        .EXT_W   (EXT_W)
    ) u_split (
        .ad_i     (ad_i),
        .type0_o  (type0),
        .select_o (select),
        .index_o  (index_c)
    );

    cfg_enable_reg u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (csr_wr_i),
        .wdata_i  (csr_wdata_i),
        .enable_o (cfg_enable_o)
    );

    cfg_claim_stage #(
        .IDX_W (IDX_W)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (addr_valid_i),
        .is_cfg_i (cmd_is_cfg_i),
        .type0_i  (type0),
        .select_i (select),
        .enable_i (cfg_enable_o),
        .index_i  (index_c),
        .claim_o  (claim_o),
        .index_o  (reg_index_o)
    );

    // Own device number: no path from the bus, only the reserved value
    always_comb begin
        self_dev_d = self_dev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            self_dev_q <= SELF_DEV;
        end else begin
            self_dev_q <= self_dev_d;
        end
    end

    assign primary_dev_o = self_dev_q;

endmodule

// File: rtl/cfg_claim_checker.sv
module cfg_claim_checker #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned SEL_BIT = 16,
    parameter int unsigned REG_LSB = 2,
    parameter int unsigned REG_W   = 6,
    parameter int unsigned EXT_LSB = 24,
    parameter int unsigned EXT_W   = 4,
    localparam int unsigned IDX_W  = EXT_W + REG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_valid_i,
    input logic              cmd_is_cfg_i,
    input logic [ADDR_W-1:0] ad_i,
    input logic              csr_wr_i,
    input logic              csr_wdata_i,
    input logic              cfg_enable_o,
    input logic              claim_o,
    input logic [IDX_W-1:0]  reg_index_o
);

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_i |=> (cfg_enable_o == $past(csr_wdata_i)));

    assert_enable_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr_i |=> $stable(cfg_enable_o));

    assert_claim_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && cmd_is_cfg_i && (ad_i[1:0] == 2'b00)
         && ad_i[SEL_BIT] && cfg_enable_o) |=> claim_o);

    assert_disabled_no_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && !cfg_enable_o) |=> !claim_o);

    assert_unselected_no_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && !ad_i[SEL_BIT]) |=> !claim_o);

    assert_wrong_kind_no_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && (!cmd_is_cfg_i || (ad_i[1:0] != 2'b00))) |=> !claim_o);

    assert_index_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> (reg_index_o == {$past(ad_i[EXT_LSB +: EXT_W]),
                                     $past(ad_i[REG_LSB +: REG_W])}));

    assert_index_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !claim_o |-> $stable(reg_index_o));

    assert_claim_needs_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> $past(addr_valid_i));

endmodule

bind cfg_claim_decoder cfg_claim_checker #(
    .ADDR_W  (ADDR_W),
    .SEL_BIT (SEL_BIT),
    .REG_LSB (REG_LSB),
    .REG_W   (REG_W),
    .EXT_LSB (EXT_LSB),
    .EXT_W   (EXT_W)
) u_claim_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_valid_i (addr_valid_i),
    .cmd_is_cfg_i (cmd_is_cfg_i),
    .ad_i         (ad_i),
    .csr_wr_i     (csr_wr_i),
    .csr_wdata_i  (csr_wdata_i),
    .cfg_enable_o (cfg_enable_o),
    .claim_o      (claim_o),
    .reg_index_o  (reg_index_o)
);

// File: tb/cfg_claim_decoder_test.sv
module cfg_claim_decoder_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 10;

    // Vector layout: {enable, cfg_cmd, ad[31:0], expect_claim}
    localparam logic [34:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 32'h0001_0004, 1'b1},   // R3 basic claim
        {1'b1, 1'b1, 32'h0F01_00FC, 1'b1},   // R8 top index
        {1'b1, 1'b1, 32'h0000_0004, 1'b0},   // R5 bit 16 low
        {1'b0, 1'b1, 32'h0001_0008, 1'b0},   // R4 disabled
        {1'b1, 1'b0, 32'h0001_0008, 1'b0},   // R6 not config
        {1'b1, 1'b1, 32'h0001_0009, 1'b0},   // R6 type bits 01
        {1'b1, 1'b1, 32'h0001_0002, 1'b0},   // R6 type bits 10
        {1'b1, 1'b1, 32'h0001_FF10, 1'b1},   // R7 dev/func all ones
        {1'b1, 1'b1, 32'h0301_0810, 1'b1},   // R7 other dev
        {1'b1, 1'b1, 32'hF001_0020, 1'b1}    // R8 reserved bits high
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        addr_valid_i;
    logic        cmd_is_cfg_i;
    logic [31:0] ad_i;
    logic        csr_wr_i;
    logic        csr_wdata_i;
    logic        cfg_enable_o;
    logic        claim_o;
    logic [9:0]  reg_index_o;
    logic [4:0]  primary_dev_o;

    int checks = 0;
    int fails  = 0;
    logic [9:0] last_idx = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_claim_decoder uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_valid_i  (addr_valid_i),
        .cmd_is_cfg_i  (cmd_is_cfg_i),
        .ad_i          (ad_i),
        .csr_wr_i      (csr_wr_i),
        .csr_wdata_i   (csr_wdata_i),
        .cfg_enable_o  (cfg_enable_o),
        .claim_o       (claim_o),
        .reg_index_o   (reg_index_o),
        .primary_dev_o (primary_dev_o)
    );

    function automatic logic [9:0] idx_of(input logic [31:0] a);
        return {a[27:24], a[7:2]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic csr_write(input logic v);
        @(negedge clk);
        csr_wr_i    = 1'b1;
        csr_wdata_i = v;
        @(negedge clk);
        csr_wr_i    = 1'b0;
        chk("R2 enable after write", 32'(cfg_enable_o), 32'(v));
    endtask

    task automatic phase(input logic cmd, input logic [31:0] a, input logic exp, input string req);
        @(negedge clk);
        addr_valid_i = 1'b1;
        cmd_is_cfg_i = cmd;
        ad_i         = a;
        @(posedge clk);
        #1;
        chk({req, " claim"}, 32'(claim_o), 32'(exp));
        if (exp) last_idx = idx_of(a);
        chk("R8 index", 32'(reg_index_o), 32'(last_idx));
        @(negedge clk);
        addr_valid_i = 1'b0;
        cmd_is_cfg_i = 1'b0;
        ad_i         = '0;
        @(posedge clk);
        #1;
        chk("R10 pulse ends", 32'(claim_o), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n        = 1'b0;
        addr_valid_i = 1'b0;
        cmd_is_cfg_i = 1'b0;
        ad_i         = '0;
        csr_wr_i     = 1'b0;
        csr_wdata_i  = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 claim in reset", 32'(claim_o), 32'd0);
        chk("R1 index in reset", 32'(reg_index_o), 32'd0);
        chk("R1 enable in reset", 32'(cfg_enable_o), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 enable after reset", 32'(cfg_enable_o), 32'd0);
        chk("R1 claim after reset", 32'(claim_o), 32'd0);

        // R4: enabled bit still 0 after reset, valid phase ignored
        phase(1'b1, 32'h0001_0004, 1'b0, "R4 reset default");

        for (int i = 0; i < NVEC; i++) begin
            if (cfg_enable_o !== VEC[i][34]) csr_write(VEC[i][34]);
            phase(VEC[i][33], VEC[i][32:1], VEC[i][0], $sformatf("R3/R4/R5/R6/R7 vec%0d", i));
        end

        // R7: same register fields, different dev/func, same index
        phase(1'b1, 32'h0001_F810, 1'b1, "R7 dev only");
        chk("R7 index ignores dev/func", 32'(reg_index_o), 32'(10'd4));

        // R9: own device number unaffected
        chk("R9 primary dev", 32'(primary_dev_o), 32'd0);

        // R11: enable write in same cycle as a phase
        csr_write(1'b0);
        @(negedge clk);
        addr_valid_i = 1'b1; cmd_is_cfg_i = 1'b1; ad_i = 32'h0001_0040;
        csr_wr_i = 1'b1; csr_wdata_i = 1'b1;
        @(posedge clk);
        #1;
        chk("R11 old enable 0 wins", 32'(claim_o), 32'd0);
        chk("R11 enable now set", 32'(cfg_enable_o), 32'd1);
        @(negedge clk);
        addr_valid_i = 1'b1; ad_i = 32'h0001_0044;
        csr_wr_i = 1'b1; csr_wdata_i = 1'b0;
        @(posedge clk);
        #1;
        chk("R11 old enable 1 wins", 32'(claim_o), 32'd1);
        chk("R11 index", 32'(reg_index_o), 32'(10'd17));
        chk("R2 cleared", 32'(cfg_enable_o), 32'd0);
        @(negedge clk);
        addr_valid_i = 1'b0; csr_wr_i = 1'b0; ad_i = '0; cmd_is_cfg_i = 1'b0;
        @(posedge clk);
        #1;
        chk("R10 claim drops", 32'(claim_o), 32'd0);
        chk("R8 index held", 32'(reg_index_o), 32'(10'd17));

        // R10/R8: back-to-back phases
        csr_write(1'b1);
        @(negedge clk);
        addr_valid_i = 1'b1; cmd_is_cfg_i = 1'b1; ad_i = 32'h0201_0008;
        @(posedge clk);
        #1;
        chk("R3 first of pair", 32'(claim_o), 32'd1);
        chk("R8 first index", 32'(reg_index_o), 32'(idx_of(32'h0201_0008)));
        @(negedge clk);
        ad_i = 32'h0501_000C;
        @(posedge clk);
        #1;
        chk("R3 second of pair", 32'(claim_o), 32'd1);
        chk("R8 second index", 32'(reg_index_o), 32'(idx_of(32'h0501_000C)));
        @(negedge clk);
        addr_valid_i = 1'b0; ad_i = '0; cmd_is_cfg_i = 1'b0;
        @(posedge clk);
        #1;
        chk("R10 after pair", 32'(claim_o), 32'd0);
        chk("R9 primary dev final", 32'(primary_dev_o), 32'd0);

        finish_run();
    end

endmodule